// File: doc/BRIEF.md
# UART Multiprocessor Address Filter

This block sits between a UART receiver and the CPU in a multi-drop network where every character carries a ninth bit. That bit tells an address byte apart from a data byte. For each received character, the block decides whether it is handed to software with a receive interrupt or silently dropped. The decision depends on a filter enable bit, a 2-bit scheme select and the node's own address.

In the address-only scheme every address byte interrupts and data bytes are dropped, so software can track frames itself. The two compare schemes check each address byte against the node address. On a match, the data bytes of that frame are accepted; on a mismatch, the frame is dropped. One of the two compare schemes also delivers the matching address byte, and the other does not. In both compare schemes the first accepted data byte of a frame is flagged as the start of a new frame. With the filter disabled, or with scheme 00, every character is delivered.

An accepted character is held with its address/data flag and its new-frame flag. It keeps the interrupt request raised until the CPU read strobe. A character accepted while one is still unread overwrites the held one and raises an overrun flag.

Top module: `mp_addr_filter`

## Requirements
- R1: When `mp_en` is 0, or `mp_mode` is 2'b00, every received character is accepted and raises `irq`, whatever its ninth bit.
- R2: With `mp_en`=1 and `mp_mode`=2'b01, address characters are accepted and data characters are dropped.
- R3: `held_is_addr` is 1 when the held character arrived with `rx_is_addr`=1, and 0 when it arrived as data.
- R4: With `mp_mode`=2'b10, an address character equal to `node_addr` is accepted, and the data characters that follow it are accepted too.
- R5: With `mp_mode`=2'b10, an address character that differs from `node_addr` is dropped. Every data character after it is also dropped until the next address character.
- R6: `new_frame` is 1 for the first accepted data character after a matching address, and 0 for later data characters of that frame, for address characters, and in modes 00 and 01.
- R7: Every new address character is compared again. A match restarts delivery with `new_frame` set on the first data character, and a mismatch suppresses data until a later match.
- R8: With `mp_mode`=2'b11, address characters are never accepted. The data characters of a matching frame are accepted as in mode 10, including the `new_frame` flag.
- R9: After reset no frame is accepted, so data characters in modes 10 and 11 are dropped until a matching address arrives.
- R10: `irq` rises on the clock edge that samples an accepted character and stays high until `rd_strobe`. A read clears `irq` and `overrun`. An acceptance in the same cycle as a read wins and leaves `irq` high with `overrun` low.
- R11: A character accepted while `irq` is high and no read occurs replaces `held_data` and sets `overrun`.
- R12: After reset `irq`, `overrun`, `new_frame`, `held_is_addr` are 0 and `held_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | DATA_W | Received character |
| rx_is_addr | input | 1 | Ninth bit: 1 for an address character |
| mp_en | input | 1 | Filter enable |
| mp_mode | input | 2 | Scheme select: 00 open, 01 address only, 10 compare with address, 11 compare data only |
| node_addr | input | DATA_W | Address of this node |
| rd_strobe | input | 1 | CPU read of the held character |
| irq | output | 1 | Receive interrupt request |
| held_data | output | DATA_W | Last accepted character |
| held_is_addr | output | 1 | Held character was an address |
| new_frame | output | 1 | Held character is the first data of an accepted frame |
| overrun | output | 1 | An accepted character overwrote an unread one |

## Verification
The bench uses the default `DATA_W` of 8 with `node_addr` fixed at 0x5A. An 8-bit width lets the vector table use matching and non-matching address values that differ in several bit positions, so the full-width compare is exercised. It also places distinct data values in every slot, so a stale or misrouted held character shows up. The walked table moves across all four schemes without a reset between them. This reaches the cases where frame state carries over between schemes: a frame that is dropped after reset, a re-match, and a mode 11 address that re-arms the new-frame flag. Directed tests then cover overrun, a read that collides with an acceptance, and how long `irq` is held.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

  typedef enum logic [1:0] {
    MPF_OPEN       = 2'b00,
    MPF_ADDR_ONLY  = 2'b01,
    MPF_MATCH_ALL  = 2'b10,
    MPF_MATCH_DATA = 2'b11
  } mpf_mode_e;

  // Filtering applies only with the enable set and a non-open scheme.
  function automatic logic f_filter_on(input logic en, input logic [1:0] mode);
    return en && (mode != MPF_OPEN);
  endfunction

  // Schemes that compare address characters with the node address.
  function automatic logic f_compare_mode(input logic [1:0] mode);
    return mode[1];
  endfunction

  // Schemes in which a matching address character is itself delivered.
  function automatic logic f_addr_delivered(input logic [1:0] mode);
    return mode == MPF_MATCH_ALL;
  endfunction

endpackage

// File: rtl/mpf_addr_cmp.sv
module mpf_addr_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] node_addr,
  output logic              addr_match
);
  logic [DATA_W-1:0] eq_bits;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      assign eq_bits[gi] = rx_data[gi] ~^ node_addr[gi];
    end
  endgenerate

  assign addr_match = &eq_bits;
endmodule

// File: rtl/mpf_classifier.sv
module mpf_classifier
  import mpf_pkg::*;
(
  input  logic       rx_valid,
  input  logic       rx_is_addr,
  input  logic       addr_match,
  input  logic       mp_en,
  input  logic [1:0] mp_mode,
  input  logic       frame_ok,
  input  logic       first_pending,
  output logic       accept,
  output logic       accept_nf,
  output logic       frame_load,
  output logic       frame_ok_d,
  output logic       first_d
);
  always_comb begin
    accept     = 1'b0;
    accept_nf  = 1'b0;
    frame_load = 1'b0;
    frame_ok_d = frame_ok;
    first_d    = first_pending;
    if (rx_valid) begin
      if (!f_filter_on(mp_en, mp_mode)) begin
        accept = 1'b1;
      end else if (!f_compare_mode(mp_mode)) begin
        accept = rx_is_addr;
      end else if (rx_is_addr) begin
        frame_load = 1'b1;
        frame_ok_d = addr_match;
        first_d    = addr_match;
        accept     = addr_match && f_addr_delivered(mp_mode);
      end else if (frame_ok) begin
        accept    = 1'b1;
        accept_nf = first_pending;
        if (first_pending) begin
          frame_load = 1'b1;
          first_d    = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mpf_frame_track.sv
module mpf_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_load,
  input  logic frame_ok_d,
  input  logic first_d,
  output logic frame_ok,
  output logic first_pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_ok      <= 1'b0;
      first_pending <= 1'b0;
    end else if (frame_load) begin
      frame_ok      <= frame_ok_d;
      first_pending <= first_d;
    end
  end
endmodule

// File: rtl/mpf_hold_reg.sv
module mpf_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              accept_nf,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_is_addr,
  input  logic              rd_strobe,
  output logic              irq,
  output logic [DATA_W-1:0] held_data,
  output logic              held_is_addr,
  output logic              new_frame,
  output logic              overrun
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq          <= 1'b0;
      held_data    <= '0;
      held_is_addr <= 1'b0;
      new_frame    <= 1'b0;
      overrun      <= 1'b0;
    end else if (accept) begin
      irq          <= 1'b1;
      held_data    <= rx_data;
      held_is_addr <= rx_is_addr;
      new_frame    <= accept_nf;
      overrun      <= rd_strobe ? 1'b0 : (overrun | irq);
    end else if (rd_strobe) begin
      irq     <= 1'b0;
      overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter
  import mpf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_is_addr,
  input  logic              mp_en,
  input  logic [1:0]        mp_mode,
  input  logic [DATA_W-1:0] node_addr,
  input  logic              rd_strobe,
  output logic              irq,
  output logic [DATA_W-1:0] held_data,
  output logic              held_is_addr,
  output logic              new_frame,
  output logic              overrun
);
  logic addr_match;
  logic accept_evt;
  logic accept_nf;
  logic frame_load;
  logic frame_ok_d;
  logic first_d;
  logic frame_ok;
  logic first_pending;

  mpf_addr_cmp #(.DATA_W(DATA_W)) u_cmp (
    .rx_data    (rx_data),
    .node_addr  (node_addr),
    .addr_match (addr_match)
  );

  mpf_classifier u_cls (
    .rx_valid      (rx_valid),
    .rx_is_addr    (rx_is_addr),
    .addr_match    (addr_match),
    .mp_en         (mp_en),
    .mp_mode       (mp_mode),
    .frame_ok      (frame_ok),
    .first_pending (first_pending),
    .accept        (accept_evt),
    .accept_nf     (accept_nf),
    .frame_load    (frame_load),
    .frame_ok_d    (frame_ok_d),
    .first_d       (first_d)
  );

  mpf_frame_track u_trk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_load    (frame_load),
    .frame_ok_d    (frame_ok_d),
    .first_d       (first_d),
    .frame_ok      (frame_ok),
    .first_pending (first_pending)
  );

  mpf_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept_evt),
    .accept_nf    (accept_nf),
    .rx_data      (rx_data),
    .rx_is_addr   (rx_is_addr),
    .rd_strobe    (rd_strobe),
    .irq          (irq),
    .held_data    (held_data),
    .held_is_addr (held_is_addr),
    .new_frame    (new_frame),
    .overrun      (overrun)
  );
endmodule

// File: rtl/mpf_checker.sv
module mpf_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_is_addr,
  input logic              mp_en,
  input logic [1:0]        mp_mode,
  input logic [DATA_W-1:0] node_addr,
  input logic              rd_strobe,
  input logic              irq,
  input logic [DATA_W-1:0] held_data,
  input logic              held_is_addr,
  input logic              new_frame,
  input logic              overrun,
  input logic              accept_evt
);
  assert_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !mp_en) |=> (irq && held_data == $past(rx_data)
                              && held_is_addr == $past(rx_is_addr)));

  assert_data_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mp_en && mp_mode == 2'b01 && !rx_is_addr && !rd_strobe)
      |=> ($stable(irq) && $stable(held_data)));

  assert_mismatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mp_en && mp_mode == 2'b10 && rx_is_addr && rx_data != node_addr
     && !rd_strobe) |=> ($stable(irq) && $stable(held_data)));

  assert_nf_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    new_frame |-> !held_is_addr);

  assert_addr_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mp_en && mp_mode == 2'b11 && rx_is_addr && !rd_strobe)
      |=> ($stable(irq) && $stable(held_data)));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(accept_evt));

  assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !accept_evt) |=> (!irq && !overrun));

  assert_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && irq && !rd_strobe) |=> overrun);
endmodule

bind mp_addr_filter mpf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_valid     (rx_valid),
  .rx_data      (rx_data),
  .rx_is_addr   (rx_is_addr),
  .mp_en        (mp_en),
  .mp_mode      (mp_mode),
  .node_addr    (node_addr),
  .rd_strobe    (rd_strobe),
  .irq          (irq),
  .held_data    (held_data),
  .held_is_addr (held_is_addr),
  .new_frame    (new_frame),
  .overrun      (overrun),
  .accept_evt   (accept_evt)
);

// File: tb/mp_addr_filter_bench.sv
`timescale 1ns/1ps
module mp_addr_filter_bench;
  localparam int DW = 8;
  localparam logic [DW-1:0] NODE = 8'h5A;

  typedef struct packed {
    logic       en;
    logic [1:0] mode;
    logic       is_addr;
    logic [7:0] data;
    logic       dlv;
    logic       nf;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b10, 1'b0, 8'h11, 1'b1, 1'b0, 4'd1},  // R1 disabled
    '{1'b1, 2'b00, 1'b1, 8'h33, 1'b1, 1'b0, 4'd3},  // R3 open, address flag
    '{1'b1, 2'b10, 1'b0, 8'h44, 1'b0, 1'b0, 4'd9},  // R9 no frame yet
    '{1'b1, 2'b01, 1'b1, 8'h77, 1'b1, 1'b0, 4'd2},  // R2 address passes
    '{1'b1, 2'b01, 1'b0, 8'h78, 1'b0, 1'b0, 4'd2},  // R2 data dropped
    '{1'b1, 2'b10, 1'b1, 8'h5A, 1'b1, 1'b0, 4'd4},  // R4 matching address
    '{1'b1, 2'b10, 1'b0, 8'h01, 1'b1, 1'b1, 4'd6},  // R6 first data
    '{1'b1, 2'b10, 1'b0, 8'h02, 1'b1, 1'b0, 4'd6},  // R6 later data
    '{1'b1, 2'b10, 1'b1, 8'hA5, 1'b0, 1'b0, 4'd5},  // R5 mismatch
    '{1'b1, 2'b10, 1'b0, 8'h03, 1'b0, 1'b0, 4'd5},  // R5 data dropped
    '{1'b1, 2'b10, 1'b1, 8'h5A, 1'b1, 1'b0, 4'd7},  // R7 re-match
    '{1'b1, 2'b10, 1'b0, 8'h04, 1'b1, 1'b1, 4'd7},  // R7 flag again
    '{1'b1, 2'b11, 1'b1, 8'h5A, 1'b0, 1'b0, 4'd8},  // R8 address silent
    '{1'b1, 2'b11, 1'b0, 8'h05, 1'b1, 1'b1, 4'd8},  // R8 first data
    '{1'b1, 2'b11, 1'b0, 8'h06, 1'b1, 1'b0, 4'd8},  // R8 later data
    '{1'b1, 2'b11, 1'b1, 8'h99, 1'b0, 1'b0, 4'd8},  // R8 mismatch
    '{1'b1, 2'b11, 1'b0, 8'h07, 1'b0, 1'b0, 4'd8},  // R8 data dropped
    '{1'b1, 2'b00, 1'b0, 8'h08, 1'b1, 1'b0, 4'd1}   // R1 mode 00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic rx_is_addr = 1'b0;
  logic mp_en = 1'b0;
  logic [1:0] mp_mode = 2'b00;
  logic [DW-1:0] node_addr = NODE;
  logic rd_strobe = 1'b0;
  logic irq, held_is_addr, new_frame, overrun;
  logic [DW-1:0] held_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  mp_addr_filter #(.DATA_W(DW)) u_mp_addr_filter (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_is_addr(rx_is_addr), .mp_en(mp_en), .mp_mode(mp_mode),
    .node_addr(node_addr), .rd_strobe(rd_strobe), .irq(irq),
    .held_data(held_data), .held_is_addr(held_is_addr),
    .new_frame(new_frame), .overrun(overrun)
  );

  task automatic chk(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Present one character for one cycle; outputs are sampled one negedge later.
  task automatic send(input logic en, input logic [1:0] mode, input logic a,
                      input logic [7:0] d);
    @(negedge clk);
    mp_en = en; mp_mode = mode; rx_is_addr = a; rx_data = d; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic read_pulse();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      checks++; errors++;
      $display("FAIL R10 watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(12, "irq at reset", int'(irq), 0);
    chk(12, "overrun at reset", int'(overrun), 0);
    chk(12, "new_frame at reset", int'(new_frame), 0);
    chk(12, "held_is_addr at reset", int'(held_is_addr), 0);
    chk(12, "held_data at reset", int'(held_data), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].en, VECS[i].mode, VECS[i].is_addr, VECS[i].data);
      chk(int'(VECS[i].req), $sformatf("vec %0d irq", i), int'(irq), int'(VECS[i].dlv));
      if (VECS[i].dlv) begin
        chk(int'(VECS[i].req), $sformatf("vec %0d data", i), int'(held_data), int'(VECS[i].data));
        chk(3, $sformatf("vec %0d addr flag", i), int'(held_is_addr), int'(VECS[i].is_addr));
        chk(6, $sformatf("vec %0d new_frame", i), int'(new_frame), int'(VECS[i].nf));
      end
      read_pulse();
    end

    // R10 irq holds across idle cycles, then read clears it
    send(1'b0, 2'b00, 1'b0, 8'hC1);
    repeat (4) @(negedge clk);
    chk(10, "irq held while idle", int'(irq), 1);
    read_pulse();
    chk(10, "irq cleared by read", int'(irq), 0);

    // R11 overrun: second accept without read
    send(1'b0, 2'b00, 1'b0, 8'hD1);
    send(1'b0, 2'b00, 1'b1, 8'hD2);
    chk(11, "overrun set", int'(overrun), 1);
    chk(11, "held replaced", int'(held_data), 'hD2);
    chk(11, "irq still set", int'(irq), 1);
    read_pulse();
    chk(10, "overrun cleared by read", int'(overrun), 0);

    // R10 read colliding with accept: accept wins, no overrun
    send(1'b0, 2'b00, 1'b0, 8'hE1);
    @(negedge clk);
    rx_data = 8'hE2; rx_is_addr = 1'b0; rx_valid = 1'b1; rd_strobe = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rd_strobe = 1'b0;
    chk(10, "collision irq", int'(irq), 1);
    chk(10, "collision overrun", int'(overrun), 0);
    chk(10, "collision data", int'(held_data), 'hE2);
    read_pulse();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule